// File: doc/BRIEF.md
# Vectored Interrupt Controller for Mode-2 CPUs

This block gathers up to sixteen active-low interrupt request lines from peripherals and presents a single active-low interrupt line to an 8-bit CPU that uses vectored (mode 2) interrupts. Each request line is synchronized and watched for its asserting (high-to-low) transition. A transition records a pending bit for that source. The level of a line on its own never records one, so software can enable a source whose line is already low without getting a spurious interrupt.

The CPU programs the block through a small I/O register window. The window holds a readable and writable enable mask, a pending register that the CPU polls and clears by writing ones, a vector base, and a status byte. When the CPU runs its interrupt acknowledge cycle, seen as M1 and IORQ both low, the block drives a vector byte. The byte holds the programmed base in its upper bits, the winning source index times two below it, and a zero in bit 0. At the end of that cycle the winner's pending bit clears. The CPU bus is a plain strobe interface with no back-pressure: a write takes effect on the clock edge where `bus_wr` is high, and `bus_rdata` follows `bus_addr` combinationally.

Top module: `irq_vec_ctrl`

## Requirements
- R1: Each `irq_n` line passes through two synchronizer flops. After a high-to-low transition driven before clock edge k, the source's pending bit and `int_n` change at edge k+2, and not earlier.
- R2: A pending bit is set only by a high-to-low transition. A line already low when its enable bit is set, or held low through reset, never makes `int_n` low. Transitions in the first three cycles after reset are ignored.
- R3: A source whose enable bit is clear still records its pending bit. Pending bits for sources 0-7 read at address 2 and for sources 8-15 at address 3, with bit i of the byte holding source i.
- R4: `int_n` is low exactly while some source is both pending and enabled.
- R5: The enable mask is written and read at address 0 (sources 0-7) and address 1 (sources 8-15), with bit i of the byte for source i.
- R6: Reset clears the enable mask, the pending bits and the vector base. It also leaves `int_n` high and `vec_oe` low.
- R7: Writing to address 2 or 3 clears the pending bits at the positions written as 1 and leaves the other pending bits unchanged.
- R8: While `m1_n` and `iorq_n` are both low, `vec_oe` is high and `vec_data` equals {base[7:5], index[3:0], 0}. The base is written at address 4, only its bits 7:5 are kept, and it reads back with bits 4:0 at zero.
- R9: The lowest-numbered source that is both pending and enabled wins. Its index is captured at the first edge of the acknowledge cycle and held until the cycle ends.
- R10: At the edge where the acknowledge cycle ends, the winner's pending bit clears and every other pending bit is kept.
- R11: Address 5 reads status: bit 7 is high while `int_n` is low, bit 4 is high when some enabled source is pending, and bits 3:0 hold the current winning index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_n | input | 16 | Active-low request lines, one per source |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Register read data for `bus_addr` |
| m1_n | input | 1 | CPU M1, active low |
| iorq_n | input | 1 | CPU IORQ, active low |
| vec_oe | output | 1 | High while the vector byte is driven |
| vec_data | output | 8 | Mode-2 vector byte |
| int_n | output | 1 | Active-low interrupt to the CPU |

## Verification
The assertions take for granted that `m1_n` and `iorq_n` are synchronous to `clk` and that an acknowledge cycle lasts at least two clock cycles. They also assume that no pending-clear write coincides with the end of an acknowledge cycle. The stimulus drives every input on the falling clock edge. It holds each acknowledge low for two edges and keeps each request level steady for at least three cycles so the synchronizer sees every transition. Register writes are kept out of acknowledge cycles.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int unsigned BUS_W = 8;

  typedef enum logic [2:0] {
    SEL_EN,
    SEL_PEND,
    SEL_BASE,
    SEL_STAT,
    SEL_NONE
  } reg_sel_e;
endpackage

// File: rtl/irq_edge_sync.sv
module irq_edge_sync #(
  parameter int unsigned N_SRC = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] line_n_i,
  output logic [N_SRC-1:0] fall_o
);
  logic [N_SRC-1:0] stg1_q, stg2_q, hist_q;
  logic [1:0]       warm_q;
  logic             armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg1_q <= '1;
      stg2_q <= '1;
      hist_q <= '1;
      warm_q <= '0;
    end else begin
      stg1_q <= line_n_i;
      stg2_q <= stg1_q;
      hist_q <= stg2_q;
      if (warm_q != 2'd3) warm_q <= warm_q + 2'd1;
    end
  end

  assign armed  = (warm_q == 2'd3);
  assign fall_o = armed ? (hist_q & ~stg2_q) : '0;
endmodule

// File: rtl/irq_prio.sv
module irq_prio #(
  parameter int unsigned N_SRC = 16,
  parameter int unsigned IDX_W = 4
) (
  input  logic [N_SRC-1:0] req_i,
  output logic             hit_o,
  output logic [IDX_W-1:0] idx_o
);
  always_comb begin
    hit_o = 1'b0;
    idx_o = '0;
    for (int i = N_SRC - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        hit_o = 1'b1;
        idx_o = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/irq_regs.sv
module irq_regs
  import irq_pkg::*;
#(
  parameter int unsigned N_SRC  = 16,
  parameter int unsigned ADDR_W = 3,
  parameter int unsigned IDX_W  = 4,
  parameter int unsigned BASE_W = BUS_W - IDX_W - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_SRC-1:0]  fall_i,
  input  logic [N_SRC-1:0]  ack_clr_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BUS_W-1:0]  wdata_i,
  input  logic              int_act_i,
  input  logic              any_i,
  input  logic [IDX_W-1:0]  win_idx_i,
  output logic [N_SRC-1:0]  en_o,
  output logic [N_SRC-1:0]  pend_o,
  output logic [BASE_W-1:0] base_o,
  output logic [BUS_W-1:0]  rdata_o
);
  localparam int unsigned NBYTE  = N_SRC / BUS_W;
  localparam int unsigned LANE_W = (NBYTE > 1) ? $clog2(NBYTE) : 1;

  reg_sel_e           sel;
  logic [LANE_W-1:0]  lane;
  logic [N_SRC-1:0]   en_q, pend_q, wclr;
  logic [BASE_W-1:0]  base_q;

  always_comb begin
    sel  = SEL_NONE;
    lane = '0;
    if (addr_i < ADDR_W'(NBYTE)) begin
      sel  = SEL_EN;
      lane = LANE_W'(addr_i);
    end else if (addr_i < ADDR_W'(2 * NBYTE)) begin
      sel  = SEL_PEND;
      lane = LANE_W'(addr_i - ADDR_W'(NBYTE));
    end else if (addr_i == ADDR_W'(2 * NBYTE)) begin
      sel = SEL_BASE;
    end else if (addr_i == ADDR_W'(2 * NBYTE + 1)) begin
      sel = SEL_STAT;
    end
  end

  for (genvar b = 0; b < NBYTE; b++) begin : g_lane
    assign wclr[b*BUS_W +: BUS_W] =
      (wr_i && sel == SEL_PEND && lane == LANE_W'(b)) ? wdata_i : '0;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) en_q[b*BUS_W +: BUS_W] <= '0;
      else if (wr_i && sel == SEL_EN && lane == LANE_W'(b))
        en_q[b*BUS_W +: BUS_W] <= wdata_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      base_q <= '0;
    end else begin
      pend_q <= (pend_q & ~wclr & ~ack_clr_i) | fall_i;
      if (wr_i && sel == SEL_BASE) base_q <= wdata_i[BUS_W-1 -: BASE_W];
    end
  end

  always_comb begin
    rdata_o = '0;
    case (sel)
      SEL_EN:   rdata_o = en_q[lane*BUS_W +: BUS_W];
      SEL_PEND: rdata_o = pend_q[lane*BUS_W +: BUS_W];
      SEL_BASE: rdata_o[BUS_W-1 -: BASE_W] = base_q;
      SEL_STAT: begin
        rdata_o[BUS_W-1]   = int_act_i;
        rdata_o[IDX_W]     = any_i;
        rdata_o[IDX_W-1:0] = win_idx_i;
      end
      default:  rdata_o = '0;
    endcase
  end

  assign en_o   = en_q;
  assign pend_o = pend_q;
  assign base_o = base_q;

  AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (en_q == '0 && pend_q == '0 && base_q == '0)); // R6

  for (genvar i = 0; i < N_SRC; i++) begin : g_chk
    AST_LEVEL_NO_SET: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pend_q[i]) |-> $past(fall_i[i])); // R2
  end
endmodule

// File: rtl/irq_vec_ctrl.sv
module irq_vec_ctrl
  import irq_pkg::*;
#(
  parameter int unsigned N_SRC  = 16,
  parameter int unsigned IDX_W  = $clog2(N_SRC),
  parameter int unsigned ADDR_W = $clog2(2 * (N_SRC / BUS_W) + 2)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_SRC-1:0]  irq_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  input  logic              m1_n,
  input  logic              iorq_n,
  output logic              vec_oe,
  output logic [BUS_W-1:0]  vec_data,
  output logic              int_n
);
  localparam int unsigned BASE_W = BUS_W - IDX_W - 1;

  logic [N_SRC-1:0]  fall_w, en_w, pend_w, live_w, ack_clr, low_mask;
  logic [BASE_W-1:0] base_w;
  logic              win_hit;
  logic [IDX_W-1:0]  win_idx, ack_idx, sel_idx;
  logic              ack, ack_q, ack_live, ack_hit, ack_start, ack_end;

  irq_edge_sync #(.N_SRC(N_SRC)) u_sync (
    .clk(clk), .rst_n(rst_n), .line_n_i(irq_n), .fall_o(fall_w)
  );

  assign live_w = pend_w & en_w;

  irq_prio #(.N_SRC(N_SRC), .IDX_W(IDX_W)) u_prio (
    .req_i(live_w), .hit_o(win_hit), .idx_o(win_idx)
  );

  irq_regs #(.N_SRC(N_SRC), .ADDR_W(ADDR_W), .IDX_W(IDX_W), .BASE_W(BASE_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .fall_i(fall_w), .ack_clr_i(ack_clr),
    .wr_i(bus_wr), .addr_i(bus_addr), .wdata_i(bus_wdata),
    .int_act_i(!int_n), .any_i(win_hit), .win_idx_i(win_idx),
    .en_o(en_w), .pend_o(pend_w), .base_o(base_w), .rdata_o(bus_rdata)
  );

  assign ack       = !m1_n && !iorq_n;
  assign ack_start = ack && !ack_q;
  assign ack_end   = !ack && ack_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_q    <= 1'b0;
      ack_live <= 1'b0;
      ack_hit  <= 1'b0;
      ack_idx  <= '0;
    end else begin
      ack_q <= ack;
      if (ack_start) begin
        ack_live <= 1'b1;
        ack_hit  <= win_hit;
        ack_idx  <= win_idx;
      end else if (ack_end) begin
        ack_live <= 1'b0;
        ack_hit  <= 1'b0;
      end
    end
  end

  assign ack_clr  = (ack_end && ack_hit) ? (N_SRC'(1) << ack_idx) : '0;
  assign sel_idx  = ack_live ? ack_idx : win_idx;
  assign vec_oe   = ack;
  assign vec_data = {base_w, sel_idx, 1'b0};
  assign int_n    = !(|live_w);
  assign low_mask = ~({N_SRC{1'b1}} << win_idx);

  AST_LOWEST_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_start && win_hit) |-> ((live_w & low_mask) == '0 && live_w[win_idx])); // R9

  AST_IDX_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_live && ack && $past(ack_live)) |-> $stable(ack_idx)); // R9

  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_end && ack_hit) |=> (!pend_w[ack_idx] || $past(fall_w[ack_idx]))); // R10
endmodule

// File: tb/test_irq_vec_ctrl.sv
module test_irq_vec_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int N = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [N-1:0] irq_n = '1;
  logic        bus_wr = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic        m1_n = 1'b1, iorq_n = 1'b1;
  logic        vec_oe;
  logic [7:0]  vec_data;
  logic        int_n;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  irq_vec_ctrl i_irq_vec_ctrl (
    .clk(clk), .rst_n(rst_n), .irq_n(irq_n), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .m1_n(m1_n), .iorq_n(iorq_n), .vec_oe(vec_oe), .vec_data(vec_data),
    .int_n(int_n)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    tick(1);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic rd_pend(output logic [15:0] p);
    logic [7:0] lo, hi;
    rd(3'd2, lo);
    rd(3'd3, hi);
    p = {hi, lo};
  endtask

  task automatic ack_cycle(output logic [7:0] v, output logic oe);
    m1_n = 1'b0; iorq_n = 1'b0;
    #1;
    v = vec_data; oe = vec_oe;
    tick(2);
    m1_n = 1'b1; iorq_n = 1'b1;
    tick(1);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0]  v, d;
    logic        oe;
    logic [15:0] p;
    @(negedge clk);
    tick(3);
    // R6 reset state
    chk("R6 int_n", int_n, 1);
    chk("R6 vec_oe", vec_oe, 0);
    for (int a = 0; a < 6; a++) begin
      rd(3'(a), d);
      chk("R6 reg read", d, 0);
    end
    rst_n = 1'b1;
    tick(4);

    // R5 enable read/write
    wr(3'd0, 8'hA5); wr(3'd1, 8'h3C);
    rd(3'd0, d); chk("R5 en lo", d, 8'hA5);
    rd(3'd1, d); chk("R5 en hi", d, 8'h3C);
    // R8 base keeps bits 7:5
    wr(3'd4, 8'hBF);
    rd(3'd4, d); chk("R8 base readback", d, 8'hA0);
    wr(3'd0, 8'hFF); wr(3'd1, 8'hFF);
    rd(3'd5, d); chk("R11 idle status", d, 0);

    // R1/R4/R8/R10 per-source sweep
    for (int i = 0; i < N; i++) begin
      irq_n[i] = 1'b0;
      tick(2);
      chk("R1 not early", int_n, 1);
      tick(1);
      chk("R1 int asserted", int_n, 0);
      rd_pend(p); chk("R3 pend bit", p, 1 << i);
      rd(3'd5, d); chk("R11 status", d, 8'h90 | i);
      ack_cycle(v, oe);
      chk("R8 vec_oe", oe, 1);
      chk("R8 vector", v, 8'hA0 | (i << 1));
      rd_pend(p); chk("R10 cleared", p, 0);
      chk("R4 int released", int_n, 1);
      irq_n[i] = 1'b1;
      tick(3);
    end

    // R9 priority over all pairs
    for (int i = 0; i < N; i++) begin
      for (int j = i + 1; j < N; j++) begin
        irq_n[i] = 1'b0; irq_n[j] = 1'b0;
        tick(3);
        rd(3'd5, d); chk("R11 winner", d, 8'h90 | i);
        ack_cycle(v, oe);
        chk("R9 lowest first", v, 8'hA0 | (i << 1));
        chk("R4 still pending", int_n, 0);
        rd_pend(p); chk("R10 other kept", p, 1 << j);
        ack_cycle(v, oe);
        chk("R9 second", v, 8'hA0 | (j << 1));
        chk("R4 none left", int_n, 1);
        irq_n[i] = 1'b1; irq_n[j] = 1'b1;
        tick(3);
      end
    end

    // R3/R7/R2 with disabled sources
    wr(3'd0, 8'h00); wr(3'd1, 8'h00);
    for (int k = 0; k < N; k++) begin
      irq_n[k] = 1'b0;
      tick(3);
      chk("R3 disabled no int", int_n, 1);
      rd_pend(p); chk("R3 polled", p, 1 << k);
      if (k < 8) wr(3'd2, 8'(1 << k)); else wr(3'd3, 8'(1 << (k - 8)));
      rd_pend(p); chk("R7 w1c", p, 0);
      if (k < 8) wr(3'd0, 8'(1 << k)); else wr(3'd1, 8'(1 << (k - 8)));
      tick(3);
      chk("R2 enable on low level", int_n, 1);
      wr(3'd0, 8'h00); wr(3'd1, 8'h00);
      irq_n[k] = 1'b1;
      tick(3);
    end

    // R7 selective clear
    irq_n[2] = 1'b0; irq_n[9] = 1'b0;
    tick(3);
    irq_n[2] = 1'b1; irq_n[9] = 1'b1;
    wr(3'd2, 8'h04);
    rd_pend(p); chk("R7 selective", p, 16'h0200);
    wr(3'd3, 8'h02);
    rd_pend(p); chk("R7 second byte", p, 0);

    // R2/R6 line held low through reset
    irq_n[3] = 1'b0;
    rst_n = 1'b0;
    tick(2);
    rd(3'd0, d); chk("R6 en cleared", d, 0);
    rst_n = 1'b1;
    tick(6);
    wr(3'd0, 8'hFF);
    tick(2);
    chk("R2 low through reset", int_n, 1);
    rd_pend(p); chk("R2 no pend", p, 0);
    irq_n[3] = 1'b1;
    tick(3);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule